// File: doc/BRIEF.md
# Bus Clock and Startup Sequencer

This block sits on the oscillator clock and decides when the CPU and peripheral clocks may run. It builds the bus clock by dividing the oscillator clock by four through two cascaded halving stages. The divided level and two phase enables mark the first and third oscillator cycles of each bus cycle. While the clocks are gated, the halvers are held at phase zero, so every restart begins from the same known phase.

One shared 12-bit cycle counter times every startup delay. After power-on the block holds the bus clocks off and drives its active-low reset output for 4096 oscillator cycles. A stop request puts it into a low-power stop state. An interrupt or a break wake leaves stop through a recovery delay of 4096 cycles, or 32 cycles when the short-delay select is high at the moment of the wake. A reset wake restarts the full power-on sequence, and so does a reset that arrives during the recovery delay. A clocks-active status goes high in the first cycle in which the phase enables run again.

Top module: `busclk_seq`

## Requirements
- R1: While por_n is low, rst_out_n, clk_active, bus_clk, ph1 and ph2 are all 0.
- R2: After por_n rises between edges, rst_out_n and clk_active stay 0 through the first 4095 rising edges of osc_clk and both become 1 at the 4096th.
- R3: While clk_active is 1, bus_clk repeats the pattern 0,0,1,1 over consecutive oscillator cycles. ph1 is 1 in the first cycle of each group of four and ph2 in the third, and ph1 and ph2 are never 1 together.
- R4: clk_active rises in the same cycle as the first ph1 pulse after a timeout.
- R5: A stop_req sampled high while clk_active is 1 makes clk_active, bus_clk, ph1 and ph2 all 0 after that edge, with rst_out_n staying 1.
- R6: In stop, a wake_irq or wake_brk sampled high with short_dly=1 brings clk_active back on the 33rd rising edge, counting the sampling edge as the first. With short_dly=0 it comes back on the 4097th. rst_out_n stays 1 throughout.
- R7: short_dly is taken only at the wake edge. Changing it during the recovery delay does not change the delay length.
- R8: wake_rst sampled high after power-on, including during the recovery delay, drives rst_out_n and clk_active to 0 after that edge. Both return to 1 on the 4097th rising edge, counting the sampling edge as the first.
- R9: wake_irq and wake_brk have no effect outside the stop state. stop_req has no effect while clk_active is 0.
- R10: After every timeout, the first active cycle has bus_clk=0 and ph1=1, which restarts the divider from phase zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | Request to enter the stop state |
| wake_irq | input | 1 | Interrupt wake from stop |
| wake_brk | input | 1 | Break wake from stop |
| wake_rst | input | 1 | Reset wake; restarts the power-on sequence |
| short_dly | input | 1 | 1 selects the 32-cycle stop recovery, 0 selects 4096 |
| bus_clk | output | 1 | Bus clock level, oscillator divided by four |
| ph1 | output | 1 | Enable for the first oscillator cycle of a bus cycle |
| ph2 | output | 1 | Enable for the third oscillator cycle of a bus cycle |
| rst_out_n | output | 1 | Reset output, active low during power-on style timeouts |
| clk_active | output | 1 | High while the bus clocks run |

## Verification
The bench measures the edge distance to each rise of clk_active and compares it with the exact value for each timeout. A counter terminal off by one, or a delay counted from the wrong edge, would show up as a count of 4095, 4097 or 34. It changes short_dly in the middle of a long recovery, so a design that read the select continuously instead of latching it would return after 33 edges. It fires a reset inside the recovery delay, where a design that ignored it or kept the short limit would release reset early. It also checks the divider phase on each restart and sends wake and stop pulses in states that must ignore them, which catches a divider that resumes mid-phase and a state machine that reacts in the wrong state.

// File: rtl/busclk_seq.sv
module busclk_seq #(
  parameter int CNT_W        = 12,
  parameter int POR_CYCLES   = 4096,
  parameter int LONG_CYCLES  = 4096,
  parameter int SHORT_CYCLES = 32
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic wake_brk,
  input  logic wake_rst,
  input  logic short_dly,
  output logic bus_clk,
  output logic ph1,
  output logic ph2,
  output logic rst_out_n,
  output logic clk_active
);

  localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

  typedef enum logic [1:0] {S_POR, S_RUN, S_STOP, S_REC} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             short_q;
  logic             h0, h1;
  logic             run;
  logic [CNT_W-1:0] rec_last;

  assign run      = (st == S_RUN);
  assign rec_last = short_q ? SHORT_LAST : LONG_LAST;

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      st      <= S_POR;
      cnt     <= '0;
      short_q <= 1'b0;
    end else if (wake_rst) begin
      st  <= S_POR;
      cnt <= '0;
    end else begin
      case (st)
        S_POR:
          if (cnt == POR_LAST) begin
            st  <= S_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_RUN:
          if (stop_req) st <= S_STOP;
        S_STOP:
          if (wake_irq || wake_brk) begin
            st      <= S_REC;
            cnt     <= '0;
            short_q <= short_dly;
          end
        S_REC:
          if (cnt == rec_last) begin
            st  <= S_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: st <= S_POR;
      endcase
    end
  end

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      h0 <= 1'b0;
      h1 <= 1'b0;
    end else if (!run) begin
      h0 <= 1'b0;
      h1 <= 1'b0;
    end else begin
      h0 <= ~h0;
      h1 <= h1 ^ h0;
    end
  end

  assign bus_clk    = run & h1;
  assign ph1        = run & ~h0 & ~h1;
  assign ph2        = run & ~h0 & h1;
  assign rst_out_n  = (st != S_POR);
  assign clk_active = run;

endmodule

module busclk_seq_chk (
  input logic osc_clk,
  input logic por_n,
  input logic stop_req,
  input logic wake_rst,
  input logic bus_clk,
  input logic ph1,
  input logic ph2,
  input logic rst_out_n,
  input logic clk_active
);

  always @(negedge osc_clk) begin
    if (!por_n)
      assert_reset_quiet_R1: assert (!rst_out_n && !clk_active && !bus_clk && !ph1 && !ph2);
  end

  assert_phase_excl_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
    $onehot0({ph1, ph2}));

  assert_ph2_high_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
    ph2 |-> bus_clk);

  assert_ph1_follow_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
    (ph1 && !stop_req && !wake_rst) |=> (!ph1 && !ph2 && !bus_clk));

  assert_start_phase_R4: assert property (@(posedge osc_clk) disable iff (!por_n)
    $rose(clk_active) |-> (ph1 && !bus_clk));

  assert_stop_gates_R5: assert property (@(posedge osc_clk) disable iff (!por_n)
    (clk_active && stop_req && !wake_rst) |=> (!clk_active && rst_out_n));

  assert_rst_wake_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
    wake_rst |=> (!rst_out_n && !clk_active));

  assert_rst_gates_R2: assert property (@(posedge osc_clk) disable iff (!por_n)
    !rst_out_n |-> !clk_active);

endmodule

bind busclk_seq busclk_seq_chk u_chk (
  .osc_clk(osc_clk), .por_n(por_n), .stop_req(stop_req), .wake_rst(wake_rst),
  .bus_clk(bus_clk), .ph1(ph1), .ph2(ph2), .rst_out_n(rst_out_n),
  .clk_active(clk_active)
);

// File: tb/busclk_seq_bench.sv
module busclk_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic osc_clk = 1'b0;
  logic por_n = 1'b0;
  logic stop_req = 1'b0, wake_irq = 1'b0, wake_brk = 1'b0, wake_rst = 1'b0, short_dly = 1'b0;
  logic bus_clk, ph1, ph2, rst_out_n, clk_active;

  int checks = 0;
  int errors = 0;
  int edge_ctr = 0;
  int mark = 0;
  bit done = 0;
  logic prev_act = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always @(posedge osc_clk) edge_ctr++;

  busclk_seq u_busclk_seq (
    .osc_clk(osc_clk), .por_n(por_n), .stop_req(stop_req), .wake_irq(wake_irq),
    .wake_brk(wake_brk), .wake_rst(wake_rst), .short_dly(short_dly),
    .bus_clk(bus_clk), .ph1(ph1), .ph2(ph2), .rst_out_n(rst_out_n),
    .clk_active(clk_active)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge osc_clk);
      @(negedge osc_clk);
    end
  endtask

  task automatic expect_rise(input int n, input string tag);
    mark = edge_ctr;
    exp_q.push_back(n);
    tag_q.push_back(tag);
  endtask

  task automatic wait_active();
    int guard = 0;
    while (!clk_active && guard < 5000) begin
      step(1);
      guard++;
    end
  endtask

  always @(negedge osc_clk) begin
    if (clk_active && !prev_act) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 actual unexpected clock start expected none");
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, edge_ctr - mark, e);
        check(t, int'(rst_out_n), 1);
        check("R10", int'({bus_clk, ph1}), 1);
      end
    end
    prev_act = clk_active;
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1", int'({rst_out_n, clk_active, bus_clk, ph1, ph2}), 0);

    // R2 power-on timeout, with a stop_req pulse that must be ignored (R9)
    por_n = 1'b1;
    expect_rise(4096, "R2");
    stop_req = 1'b1;
    step(1);
    stop_req = 1'b0;
    step(4094);
    check("R2", int'({rst_out_n, clk_active}), 0);
    wait_active();
    check("R9", int'(clk_active), 1);

    // R3 R4 divider pattern over eight cycles
    check("R4", int'(ph1), 1);
    for (int i = 0; i < 8; i++) begin
      check("R3", int'(bus_clk), (i % 4) >= 2 ? 1 : 0);
      check("R3", int'(ph1), (i % 4) == 0 ? 1 : 0);
      check("R3", int'(ph2), (i % 4) == 2 ? 1 : 0);
      step(1);
    end

    // R9 wakes outside stop ignored
    wake_irq = 1'b1; wake_brk = 1'b1;
    step(1);
    wake_irq = 1'b0; wake_brk = 1'b0;
    step(2);
    check("R9", int'(clk_active), 1);

    // R5 stop entry, mid phase
    step(1);
    stop_req = 1'b1;
    step(1);
    stop_req = 1'b0;
    check("R5", int'({clk_active, bus_clk, ph1, ph2}), 0);
    check("R5", int'(rst_out_n), 1);
    step(5);
    check("R5", int'(clk_active), 0);

    // R6 short recovery via interrupt, stop_req held during delay (R9)
    short_dly = 1'b1;
    wake_irq = 1'b1;
    expect_rise(33, "R6");
    step(1);
    wake_irq = 1'b0;
    stop_req = 1'b1;
    step(20);
    check("R6", int'({rst_out_n, clk_active}), 2);
    stop_req = 1'b0;
    wait_active();
    step(3);

    // R6 R7 long recovery via break, select flipped after wake edge
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    short_dly = 1'b0;
    step(2);
    wake_brk = 1'b1;
    expect_rise(4097, "R7");
    step(1);
    wake_brk = 1'b0;
    short_dly = 1'b1;
    step(40);
    check("R7", int'(clk_active), 0);
    wait_active();
    step(3);

    // R8 reset during short recovery delay
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    step(2);
    wake_irq = 1'b1; step(1); wake_irq = 1'b0;
    step(10);
    wake_rst = 1'b1;
    expect_rise(4097, "R8");
    step(1);
    wake_rst = 1'b0;
    check("R8", int'({rst_out_n, clk_active}), 0);
    step(40);
    check("R8", int'(rst_out_n), 0);
    wait_active();
    step(2);
    check("R8", int'(exp_q.size()), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule